// File: doc/BRIEF.md
# Shared-Timer Input Debounce Filter

This block cleans up a 32-pin bank of general-purpose inputs. Each raw input first passes through a two-flop synchronizer. It then either goes straight to the output or goes through a stability filter. The filter updates the clean value only once the synchronized input has held a new level for a programmed number of clock cycles.

Pins do not carry their own period settings. Three period registers are shared by the whole bank. Each pin picks one of them, or none, through a 2-bit code. The high bit of that code lives in one select register and the low bit in a second select register, both at the pin's bit position. Software decides which pins share which timer. The block only applies the choice.

Some pins of the bank can only drive and have no input path. A parameter mask marks the pins that can take input. The pins left out of the mask never debounce, whatever software writes.

Top module: `dbn_bank_filter`

## Requirements
- R1: After reset every register reads 0, `pins_clean` is 0, and every pin is in bypass.
- R2: Register byte addresses are: select-high at 0x00, select-low at 0x04, and the periods of timers 1, 2 and 3 at 0x10, 0x14 and 0x18 (the low 16 bits hold the period). A write takes effect on its clock edge. A read returns the value on `bus_rdata` after the edge that accepts it. Reads of other addresses return 0, and writes to them change nothing.
- R3: The timer code of pin i is {select-high[i], select-low[i]}. Code 0 means bypass. Codes 1 to 3 pick the timer of the same number.
- R4: In bypass, a raw change applied before rising edge k shows on `pins_clean` after edge k+2.
- R5: For a pin on a timer with period P ≥ 1, a raw change applied before edge k that stays put shows on `pins_clean` after edge k+1+P and not earlier.
- R6: If the synchronized input returns to the clean value before P cycles have passed, the count restarts and `pins_clean` does not change.
- R7: A period of 0 on a selected timer gives the same timing as bypass.
- R8: A pin latches the period when its count starts. A period written during a count leaves that count alone. The next count uses the new value.
- R9: Pins outside `INPUT_MASK` (default: bits 31..28 cleared) read 0 in both select registers and always behave as bypass.
- R10: Pins on different timers count against their own periods at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid after the accepting edge |
| pins_raw | input | 32 | Asynchronous raw pin levels |
| pins_clean | output | 32 | Synchronized and filtered pin levels |

## Verification
The bench checks the exact edge on which each output bit flips, sampling one cycle before and on that edge. A filter that is off by one in its count compare, or that counts from the wrong stage of the synchronizer, shows up as a mismatch on one of the two samples. A glitch shorter than the period is fed to a debounced pin: a design that kept its count across the glitch instead of restarting it would flip the output. A period is rewritten mid-count: a design that reads the live register instead of the latched value flips too early. Other checks cover a period of 0 on a selected timer, three timers running at once, and an output-only pin with a nonzero select written to it. A design that honoured that select would be late on the output-only pin and would read back a nonzero select.

// File: rtl/dbn_pkg.sv
`timescale 1ns/1ps
package dbn_pkg;
  // Width of a pin's timer choice; code 0 is bypass, the rest name timers.
  localparam int SEL_W     = 2;
  localparam int TIMER_CNT = (1 << SEL_W) - 1;

  // Register byte offsets; the two select halves sit one word apart.
  localparam logic [7:0] OFS_SEL_HI      = 8'h00;
  localparam logic [7:0] OFS_SEL_LO      = 8'h04;
  localparam logic [7:0] OFS_PERIOD_BASE = 8'h10;
  localparam int         WORD_STRIDE     = 4;

  typedef logic [SEL_W-1:0] tsel_t;

  // Combine the two register halves into a pin's timer code.
  function automatic tsel_t join_sel(input logic hi_bit, input logic lo_bit);
    return {hi_bit, lo_bit};
  endfunction

  // Byte offset of the period register of timer index idx (0-based).
  function automatic logic [7:0] period_ofs(input int idx);
    return OFS_PERIOD_BASE + 8'(WORD_STRIDE * idx);
  endfunction
endpackage

// File: rtl/dbn_regs.sv
`timescale 1ns/1ps
module dbn_regs
  import dbn_pkg::*;
#(
  parameter int               PIN_W      = 32,
  parameter int               PERIOD_W   = 16,
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 32,
  parameter logic [PIN_W-1:0] INPUT_MASK = '1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_valid,
  input  logic                               bus_write,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [DATA_W-1:0]                  bus_wdata,
  output logic [DATA_W-1:0]                  bus_rdata,
  output logic [PIN_W-1:0]                   sel_hi,
  output logic [PIN_W-1:0]                   sel_lo,
  output logic [TIMER_CNT-1:0][PERIOD_W-1:0] periods
);
  // Named access events for the assertions.
  logic wr_req, rd_req;
  logic hit_hi, hit_lo, hit_any;
  logic [TIMER_CNT-1:0] hit_per;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata;

  assign wr_req  = bus_valid & bus_write;
  assign rd_req  = bus_valid & ~bus_write;
  assign hit_hi  = (bus_addr == ADDR_W'(OFS_SEL_HI));
  assign hit_lo  = (bus_addr == ADDR_W'(OFS_SEL_LO));
  assign hit_any = hit_hi | hit_lo | (|hit_per);
  assign unused_wdata = ^bus_wdata;

  // Select halves: bits of pins without an input path are kept at 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi <= '0;
      sel_lo <= '0;
    end else if (wr_req) begin
      if (hit_hi) sel_hi <= bus_wdata[PIN_W-1:0] & INPUT_MASK;
      if (hit_lo) sel_lo <= bus_wdata[PIN_W-1:0] & INPUT_MASK;
    end
  end

  // One period register per shared timer.
  for (genvar t = 0; t < TIMER_CNT; t++) begin : g_period
    logic [PERIOD_W-1:0] per_q;
    assign hit_per[t] = (bus_addr == ADDR_W'(period_ofs(t)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 per_q <= '0;
      else if (wr_req && hit_per[t]) per_q <= bus_wdata[PERIOD_W-1:0];
    end
    assign periods[t] = per_q;

    AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && hit_per[t]) |=> (per_q == $past(bus_wdata[PERIOD_W-1:0]))); // R2
  end

  always_comb begin
    rd_mux = '0;
    if (hit_hi) rd_mux = DATA_W'(sel_hi);
    if (hit_lo) rd_mux = DATA_W'(sel_lo);
    for (int t = 0; t < TIMER_CNT; t++) begin
      if (hit_per[t]) rd_mux = DATA_W'(periods[t]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_mux;
  end

  AST_SEL_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_hi | sel_lo) & ~INPUT_MASK) == '0); // R9

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !hit_any) |=> (bus_rdata == '0)); // R2
endmodule

// File: rtl/dbn_sync.sv
`timescale 1ns/1ps
module dbn_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= d;
    end
  end else begin : g_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbn_lane.sv
`timescale 1ns/1ps
module dbn_lane
  import dbn_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               din,
  input  tsel_t                              sel,
  input  logic [TIMER_CNT-1:0][PERIOD_W-1:0] periods,
  output logic                               dout
);
  localparam logic [PERIOD_W:0] ONE_X = {{PERIOD_W{1'b0}}, 1'b1};

  // True once this cycle closes a run of lim differing cycles.
  function automatic logic count_reached(input logic [PERIOD_W-1:0] c,
                                         input logic [PERIOD_W-1:0] l);
    return ({1'b0, c} + ONE_X) >= {1'b0, l};
  endfunction

  logic [PERIOD_W-1:0] cnt, held, live, lim_eff;
  logic lane_bypass, lane_differ, lane_done, lane_start;

  // Period of the chosen timer as it stands now.
  always_comb begin
    live = '0;
    for (int t = 0; t < TIMER_CNT; t++) begin
      if (sel == tsel_t'(t + 1)) live = periods[t];
    end
  end

  assign lane_bypass = (sel == '0);
  assign lane_differ = (din != dout);
  assign lane_start  = !lane_bypass && lane_differ && (cnt == '0);
  assign lim_eff     = lane_start ? live : held;
  assign lane_done   = count_reached(cnt, lim_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 1'b0;
      cnt  <= '0;
      held <= '0;
    end else if (lane_bypass) begin
      dout <= din;
      cnt  <= '0;
    end else if (!lane_differ) begin
      cnt  <= '0;
    end else if (lane_done) begin
      dout <= din;
      cnt  <= '0;
    end else begin
      cnt  <= cnt + 1'b1;
      held <= lim_eff;
    end
  end

  AST_BYPASS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    lane_bypass |=> (dout == $past(din))); // R4

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_bypass && lane_differ && !lane_done) |=> (dout == $past(dout))); // R6

  AST_RESTART_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_bypass && !lane_differ) |=> (cnt == '0)); // R6

  AST_CNT_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt < held)); // R8
endmodule

// File: rtl/dbn_bank_filter.sv
`timescale 1ns/1ps
module dbn_bank_filter
  import dbn_pkg::*;
#(
  parameter int               PIN_W       = 32,
  parameter int               PERIOD_W    = 16,
  parameter int               ADDR_W      = 8,
  parameter int               DATA_W      = 32,
  parameter int               SYNC_STAGES = 2,
  parameter logic [PIN_W-1:0] INPUT_MASK  = 32'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  pins_raw,
  output logic [PIN_W-1:0]  pins_clean
);
  logic [PIN_W-1:0] sel_hi, sel_lo, pins_synced, clean_w;
  logic [TIMER_CNT-1:0][PERIOD_W-1:0] periods;
  logic unused_sel;

  assign unused_sel = ^(({sel_hi, sel_lo}) & ~{INPUT_MASK, INPUT_MASK});

  dbn_regs #(
    .PIN_W(PIN_W), .PERIOD_W(PERIOD_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .INPUT_MASK(INPUT_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sel_hi(sel_hi), .sel_lo(sel_lo), .periods(periods)
  );

  dbn_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_synced)
  );

  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    if (INPUT_MASK[p]) begin : g_filt
      dbn_lane #(.PERIOD_W(PERIOD_W)) u_lane (
        .clk(clk), .rst_n(rst_n),
        .din(pins_synced[p]),
        .sel(join_sel(sel_hi[p], sel_lo[p])),
        .periods(periods),
        .dout(clean_w[p])
      );
    end else begin : g_plain
      // No input path: a flop keeps the bypass timing of filtered pins.
      logic q_bit;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_bit <= 1'b0;
        else        q_bit <= pins_synced[p];
      end
      assign clean_w[p] = q_bit;

      AST_OUTPUT_ONLY_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (clean_w[p] == $past(pins_synced[p]))); // R9
    end
  end

  assign pins_clean = clean_w;
endmodule

// File: tb/dbn_bank_filter_test.sv
`timescale 1ns/1ps
module dbn_bank_filter_test;
  localparam logic [7:0] A_SELH = 8'h00;
  localparam logic [7:0] A_SELL = 8'h04;
  localparam logic [7:0] A_PER1 = 8'h10;
  localparam logic [7:0] A_PER2 = 8'h14;
  localparam logic [7:0] A_PER3 = 8'h18;
  localparam logic [7:0] A_NONE = 8'h08;

  logic clk = 1'b0, rst_n = 1'b0, bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr  = '0;
  logic [31:0] bus_wdata = '0, pins_raw = '0;
  logic [31:0] bus_rdata, pins_clean;

  always #5 clk = ~clk;

  dbn_bank_filter uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_raw(pins_raw), .pins_clean(pins_clean)
  );

  int cyc = 0, n_checks = 0, n_fail = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; logic [31:0] mask; logic [31:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  task automatic push_exp(input int at, input logic [31:0] mask, input logic [31:0] val,
                          input string tag);
    exp_t e;
    e.at = at; e.mask = mask; e.val = val; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Raw change driven now (before edge cyc+1): flips after edge cyc+2+max(P,1).
  task automatic push_edge(input logic [31:0] mask, input logic [31:0] oldv,
                           input logic [31:0] newv, input int period, input string tag);
    int lat;
    lat = 2 + ((period < 1) ? 1 : period);
    push_exp(cyc + lat - 1, mask, oldv, tag);
    push_exp(cyc + lat, mask, newv, tag);
  endtask

  // Monitor: compares due items away from the active edge.
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].at <= cyc) begin
        n_checks++;
        if (sb_q[i].at < cyc || ((pins_clean & sb_q[i].mask) != (sb_q[i].val & sb_q[i].mask))) begin
          n_fail++;
          $display("FAIL %s: pins_clean %h expected %h (mask %h)", sb_q[i].tag,
                   pins_clean & sb_q[i].mask, sb_q[i].val & sb_q[i].mask, sb_q[i].mask);
        end
        sb_q.delete(i);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] expv, input string tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    n_checks++;
    if (bus_rdata !== expv) begin
      n_fail++;
      $display("FAIL %s: rdata %h expected %h", tag, bus_rdata, expv);
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1: reset state
    n_checks++;
    if (pins_clean !== 32'h0) begin
      n_fail++;
      $display("FAIL R1: pins_clean %h expected %h", pins_clean, 32'h0);
    end
    bus_rd(A_PER1, 32'h0, "R1 period reset");
    bus_rd(A_SELH, 32'h0, "R1 select reset");

    // R4: bypass latency on every pin
    pins_raw = 32'hA5A5_0F0F;
    push_edge(32'hFFFF_FFFF, 32'h0, 32'hA5A5_0F0F, 0, "R4 bypass rise");
    tick(6);
    pins_raw = 32'h0;
    push_edge(32'hFFFF_FFFF, 32'hA5A5_0F0F, 32'h0, 0, "R4 bypass fall");
    tick(6);

    // R2: register access
    bus_wr(A_PER1, 32'hDEAD_0005);
    bus_wr(A_PER2, 32'd12);
    bus_wr(A_PER3, 32'd3);
    bus_wr(A_NONE, 32'hFFFF_FFFF);
    bus_rd(A_PER1, 32'h0000_0005, "R2 period1 low 16 bits");
    bus_rd(A_PER2, 32'd12, "R2 period2");
    bus_rd(A_PER3, 32'd3, "R2 period3");
    bus_rd(A_NONE, 32'h0, "R2 unmapped read");

    // R3/R9: pin0->timer1, pin1->timer2, pin2->timer3, pin31 (no input)->timer3
    bus_wr(A_SELH, 32'h8000_0006);
    bus_wr(A_SELL, 32'h8000_0005);
    bus_rd(A_SELH, 32'h0000_0006, "R9 select-high masked");
    bus_rd(A_SELL, 32'h0000_0005, "R9 select-low masked");

    // R10/R5: three timers and an output-only pin at once
    pins_raw = 32'h8000_0007;
    push_edge(32'h8000_0000, 32'h0, 32'h8000_0000, 0, "R9 output-only pin bypass");
    push_edge(32'h0000_0004, 32'h0, 32'h4, 3, "R10 timer3 pin");
    push_edge(32'h0000_0001, 32'h0, 32'h1, 5, "R5 timer1 pin");
    push_edge(32'h0000_0002, 32'h0, 32'h2, 12, "R10 timer2 pin");
    push_exp(cyc + 8, 32'h7FFF_FFF8, 32'h0, "R3 unselected pins quiet");
    tick(20);

    // R6: glitch of 3 cycles on a period-5 pin
    pins_raw[0] = 1'b0;
    push_exp(cyc + 3, 32'h1, 32'h1, "R6 glitch held");
    push_exp(cyc + 6, 32'h1, 32'h1, "R6 glitch held");
    push_exp(cyc + 9, 32'h1, 32'h1, "R6 glitch held");
    push_exp(cyc + 12, 32'h1, 32'h1, "R6 glitch held");
    tick(3);
    pins_raw[0] = 1'b1;
    tick(15);
    pins_raw[0] = 1'b0;
    push_edge(32'h1, 32'h1, 32'h0, 5, "R5 steady fall");
    tick(12);

    // R8: period rewritten in the middle of a count
    pins_raw[1] = 1'b0;
    push_edge(32'h2, 32'h2, 32'h0, 12, "R8 count keeps old period");
    tick(4);
    bus_wr(A_PER2, 32'd2);
    tick(16);
    pins_raw[1] = 1'b1;
    push_edge(32'h2, 32'h0, 32'h2, 2, "R8 next count uses new period");
    tick(8);

    // R7: period 0 on a selected timer
    bus_wr(A_PER3, 32'd0);
    pins_raw[2] = 1'b0;
    push_edge(32'h4, 32'h4, 32'h0, 0, "R7 zero period");
    tick(6);

    // R3: clearing the selects returns every pin to bypass
    bus_wr(A_SELH, 32'h0);
    bus_wr(A_SELL, 32'h0);
    bus_rd(A_SELL, 32'h0, "R3 select cleared");
    pins_raw = 32'h1234_5678;
    push_edge(32'hFFFF_FFFF, 32'h8000_0002, 32'h1234_5678, 0, "R3 all bypass");
    tick(6);

    while (sb_q.size() != 0) tick(1);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run still busy %0d expected 0 pending", sb_q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule